// File: doc/BRIEF.md
# Multiprocessor Boot Role Controller

Each processor in a multiprocessor system has one copy of this controller. After reset it watches a shared serial interrupt bus. Every message on that bus carries the sender's 4-bit ID, a 3-bit kind and an 8-bit payload. The controller settles whether its processor becomes the bootstrap processor (BSP) or an application processor (AP). It then tells the processor where to begin fetching code and follows it into the halted or shutdown state.

Role is decided by arbitration messages. After reset every processor places one arbitration message on the bus. The processor whose own ID is carried by the first arbitration message that is seen becomes the BSP; every other processor becomes an AP. From then on the BSP responds only to the final message. It fetches from the reset vector. The APs wait for a startup message, whose payload selects their entry point. When an AP's startup code completes, the AP disables its interrupts and halts. A halted AP wakes only for INIT, NMI or SMI. A bus error seen during initialization shuts the processor down until the next hardware reset.

Top module: `boot_role_ctrl`

## Requirements
- R1: While `role` is 0 (undecided), an arbitration message (kind 0) makes `role` 1 (BSP) if its source equals `self_id`, and 2 (AP) otherwise. The new role is visible in the cycle after the message is sampled. Reset leaves `role` at 0.
- R2: Once `role` is non-zero, further arbitration messages never change it.
- R3: A final message (kind 1) sent to a BSP that is waiting for it raises `fetch_start` with `fetch_addr` = 32'hFFFF_FFF0. An AP ignores final messages.
- R4: A startup message (kind 2) with payload VV, sent to an AP that is waiting for startup, raises `fetch_start` with `fetch_addr` = VV placed in bits 19:12 and all other bits zero. A BSP ignores startup messages.
- R5: `fetch_start` is high for exactly one cycle, the cycle after the triggering message is sampled. `fetch_addr` is valid in that same cycle.
- R6: A startup fetch sets `intr_enable`. While the AP runs its startup code, a high `done` input makes `halted` 1 and clears `intr_enable`.
- R7: While halted, arbitration, final, startup and error messages (kinds 0, 1, 2, 6) have no effect. There is no fetch, and the AP stays halted and does not shut down.
- R8: While halted, an NMI (kind 4) pulses `nmi_taken` and an SMI (kind 5) pulses `smi_taken`, each for one cycle, and the AP stays halted. In any other state both kinds are ignored.
- R9: An INIT (kind 3) while halted returns the AP to waiting for startup. `halted` falls and `role` stays 2. A later startup message fetches again as in R4.
- R10: An error message (kind 6; payload bit 0 tells a checksum error (0) from an acceptance error (1)) in any state other than halted sets `shutdown`. Only reset clears it. INIT and every other message are ignored while shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| self_id | input | 4 | This processor's ID |
| msg_valid | input | 1 | A bus message is present this cycle |
| msg_src | input | 4 | Sender ID of the message |
| msg_kind | input | 3 | 0 arb, 1 final, 2 startup, 3 INIT, 4 NMI, 5 SMI, 6 error, 7 unused |
| msg_payload | input | 8 | Startup vector or error class |
| done | input | 1 | AP startup code has completed |
| role | output | 2 | 0 undecided, 1 BSP, 2 AP |
| fetch_start | output | 1 | One-cycle fetch strobe |
| fetch_addr | output | 32 | Physical fetch address |
| intr_enable | output | 1 | Interrupt-enable flag |
| halted | output | 1 | AP is halted |
| shutdown | output | 1 | Processor is shut down |
| nmi_taken | output | 1 | One-cycle NMI acceptance while halted |
| smi_taken | output | 1 | One-cycle SMI acceptance while halted |

## Verification
The assertions assume that the bus carries at most one message per cycle. They also assume that `self_id` stays constant between resets and that `done` is only meaningful after a startup fetch. The stimulus drives four controllers with IDs 0 to 3 from one shared bus. It places a single message for one cycle at a time and pulses `done` only for controllers that have become APs. Which processor wins arbitration, the later arbitration senders and the startup vectors are drawn at random from a fixed seed. Directed cases add the vectors 8'h00 and 8'hFF and an error before any arbitration.

// File: rtl/boot_role_pkg.sv
package boot_role_pkg;

  typedef enum logic [2:0] {
    MK_ARB     = 3'd0,
    MK_FINAL   = 3'd1,
    MK_STARTUP = 3'd2,
    MK_INIT    = 3'd3,
    MK_NMI     = 3'd4,
    MK_SMI     = 3'd5,
    MK_ERROR   = 3'd6,
    MK_RSVD    = 3'd7
  } msg_kind_e;

  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_BOOT = 2'd1,
    ROLE_APP  = 2'd2
  } role_e;

  typedef enum logic [2:0] {
    ST_ARB,
    ST_BOOT_WAIT,
    ST_BOOT_RUN,
    ST_APP_WAIT,
    ST_APP_RUN,
    ST_APP_HALT,
    ST_DOWN
  } ctrl_state_e;

  typedef struct packed {
    logic arb_self;
    logic arb_other;
    logic final_m;
    logic startup;
    logic init;
    logic nmi;
    logic smi;
    logic error;
  } bus_evt_t;

endpackage

// File: rtl/boot_msg_decode.sv
module boot_msg_decode
  import boot_role_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_src,
  input  logic [2:0]      msg_kind,
  input  logic [ID_W-1:0] self_id,
  output bus_evt_t        evt
);

  msg_kind_e kind;
  logic      from_self;

  assign kind      = msg_kind_e'(msg_kind);
  assign from_self = (msg_src == self_id);

  always_comb begin
    evt = '0;
    if (msg_valid) begin
      unique case (kind)
        MK_ARB: begin
          evt.arb_self  = from_self;
          evt.arb_other = !from_self;
        end
        MK_FINAL:   evt.final_m = 1'b1;
        MK_STARTUP: evt.startup = 1'b1;
        MK_INIT:    evt.init    = 1'b1;
        MK_NMI:     evt.nmi     = 1'b1;
        MK_SMI:     evt.smi     = 1'b1;
        MK_ERROR:   evt.error   = 1'b1;
        default:    evt         = '0;
      endcase
    end
  end

endmodule

// File: rtl/boot_role_fsm.sv
module boot_role_fsm
  import boot_role_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  bus_evt_t    evt,
  input  logic        done,
  output ctrl_state_e state,
  output role_e       role,
  output logic        launch_boot,
  output logic        launch_app,
  output logic        intr_enable,
  output logic        halted,
  output logic        shutdown,
  output logic        nmi_taken,
  output logic        smi_taken
);

  ctrl_state_e state_q, state_d;
  role_e       role_q, role_d;
  logic        ie_q, ie_d;
  logic        nmi_q, smi_q;
  logic        err_live;
  logic        halt_enter;

  // Errors count in every state except halted and already down.
  assign err_live    = evt.error && (state_q != ST_APP_HALT) && (state_q != ST_DOWN);
  assign launch_boot = (state_q == ST_BOOT_WAIT) && evt.final_m;
  assign launch_app  = (state_q == ST_APP_WAIT) && evt.startup;
  assign halt_enter  = (state_q == ST_APP_RUN) && done && !err_live;

  always_comb begin
    state_d = state_q;
    role_d  = role_q;
    ie_d    = ie_q;
    if (err_live) begin
      state_d = ST_DOWN;
    end else begin
      unique case (state_q)
        ST_ARB: begin
          if (evt.arb_self) begin
            state_d = ST_BOOT_WAIT;
            role_d  = ROLE_BOOT;
          end else if (evt.arb_other) begin
            state_d = ST_APP_WAIT;
            role_d  = ROLE_APP;
          end
        end
        ST_BOOT_WAIT: if (launch_boot) state_d = ST_BOOT_RUN;
        ST_BOOT_RUN:  state_d = ST_BOOT_RUN;
        ST_APP_WAIT: begin
          if (launch_app) begin
            state_d = ST_APP_RUN;
            ie_d    = 1'b1;
          end
        end
        ST_APP_RUN: begin
          if (halt_enter) begin
            state_d = ST_APP_HALT;
            ie_d    = 1'b0;
          end
        end
        ST_APP_HALT: if (evt.init) state_d = ST_APP_WAIT;
        ST_DOWN:     state_d = ST_DOWN;
        default:     state_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARB;
      role_q  <= ROLE_NONE;
      ie_q    <= 1'b0;
      nmi_q   <= 1'b0;
      smi_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      role_q  <= role_d;
      ie_q    <= ie_d;
      nmi_q   <= (state_q == ST_APP_HALT) && evt.nmi;
      smi_q   <= (state_q == ST_APP_HALT) && evt.smi;
    end
  end

  assign state       = state_q;
  assign role        = role_q;
  assign intr_enable = ie_q;
  assign halted      = (state_q == ST_APP_HALT);
  assign shutdown    = (state_q == ST_DOWN);
  assign nmi_taken   = nmi_q;
  assign smi_taken   = smi_q;

  a_r2_role_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q != ROLE_NONE) |=> (role_q == $past(role_q)));

  a_r10_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  a_r6_halt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> ($past(done) && !intr_enable));

  a_r8_nmi_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_taken || smi_taken) |-> halted);

  a_r7_halt_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && evt.error) |=> !shutdown);

endmodule

// File: rtl/boot_fetch_gen.sv
module boot_fetch_gen #(
  parameter int          ADDR_W    = 32,
  parameter int          VEC_W     = 8,
  parameter int          VEC_LSB   = 12,
  parameter logic [31:0] RESET_VEC = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_boot,
  input  logic              launch_app,
  input  logic [VEC_W-1:0]  vector,
  output logic              fetch_start,
  output logic [ADDR_W-1:0] fetch_addr
);

  localparam int HI_W = ADDR_W - VEC_LSB - VEC_W;

  function automatic logic [ADDR_W-1:0] app_entry(input logic [VEC_W-1:0] v);
    return {{HI_W{1'b0}}, v, {VEC_LSB{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] boot_entry();
    return ADDR_W'(RESET_VEC);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_start <= 1'b0;
      fetch_addr  <= '0;
    end else begin
      fetch_start <= launch_boot || launch_app;
      if (launch_boot)     fetch_addr <= boot_entry();
      else if (launch_app) fetch_addr <= app_entry(vector);
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);

  a_r4_app_addr: assert property (@(posedge clk) disable iff (!rst_n)
    launch_app |=> (fetch_start && fetch_addr[VEC_LSB+VEC_W-1:VEC_LSB] == $past(vector)));

endmodule

// File: rtl/boot_role_ctrl.sv
module boot_role_ctrl
  import boot_role_pkg::*;
#(
  parameter int          ID_W      = 4,
  parameter int          VEC_W     = 8,
  parameter int          ADDR_W    = 32,
  parameter int          VEC_LSB   = 12,
  parameter logic [31:0] RESET_VEC = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   self_id,
  input  logic              msg_valid,
  input  logic [ID_W-1:0]   msg_src,
  input  logic [2:0]        msg_kind,
  input  logic [VEC_W-1:0]  msg_payload,
  input  logic              done,
  output logic [1:0]        role,
  output logic              fetch_start,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              intr_enable,
  output logic              halted,
  output logic              shutdown,
  output logic              nmi_taken,
  output logic              smi_taken
);

  bus_evt_t    evt;
  ctrl_state_e state;
  role_e       role_st;
  logic        launch_boot;
  logic        launch_app;

  boot_msg_decode #(.ID_W(ID_W)) u_decode (
    .msg_valid (msg_valid),
    .msg_src   (msg_src),
    .msg_kind  (msg_kind),
    .self_id   (self_id),
    .evt       (evt)
  );

  boot_role_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .done        (done),
    .state       (state),
    .role        (role_st),
    .launch_boot (launch_boot),
    .launch_app  (launch_app),
    .intr_enable (intr_enable),
    .halted      (halted),
    .shutdown    (shutdown),
    .nmi_taken   (nmi_taken),
    .smi_taken   (smi_taken)
  );

  boot_fetch_gen #(
    .ADDR_W    (ADDR_W),
    .VEC_W     (VEC_W),
    .VEC_LSB   (VEC_LSB),
    .RESET_VEC (RESET_VEC)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_boot (launch_boot),
    .launch_app  (launch_app),
    .vector      (msg_payload),
    .fetch_start (fetch_start),
    .fetch_addr  (fetch_addr)
  );

  assign role = role_st;

  a_r1_self_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 3'd0 && state == ST_ARB && !evt.error && msg_src == self_id)
      |=> (role == 2'd1));

  a_r1_other_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 3'd0 && state == ST_ARB && msg_src != self_id)
      |=> (role == 2'd2));

  a_r3_boot_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && role == 2'd1) |-> (fetch_addr == ADDR_W'(RESET_VEC)));

  a_r3_app_no_final: assert property (@(posedge clk) disable iff (!rst_n)
    (role == 2'd2 && msg_valid && msg_kind == 3'd1) |=> !fetch_start);

endmodule

// File: tb/boot_role_ctrl_tb.sv
module boot_role_ctrl_tb;

  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_valid = 1'b0;
  logic [3:0]  m_src = '0;
  logic [2:0]  m_kind = '0;
  logic [7:0]  m_pay = '0;
  logic        done_v [NP];
  logic [1:0]  role_v [NP];
  logic        fetch_v [NP];
  logic [31:0] addr_v [NP];
  logic        ie_v [NP];
  logic        halt_v [NP];
  logic        down_v [NP];
  logic        nmi_v [NP];
  logic        smi_v [NP];

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NP; g++) begin : g_dut
    boot_role_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .self_id     (4'(g)),
      .msg_valid   (m_valid),
      .msg_src     (m_src),
      .msg_kind    (m_kind),
      .msg_payload (m_pay),
      .done        (done_v[g]),
      .role        (role_v[g]),
      .fetch_start (fetch_v[g]),
      .fetch_addr  (addr_v[g]),
      .intr_enable (ie_v[g]),
      .halted      (halt_v[g]),
      .shutdown    (down_v[g]),
      .nmi_taken   (nmi_v[g]),
      .smi_taken   (smi_v[g])
    );
  end

  function automatic logic [31:0] exp_app_addr(input logic [7:0] v);
    return 32'(v) * 32'd4096;
  endfunction

  function automatic logic [31:0] exp_boot_addr();
    return ~32'h0000_000F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] s, input logic [2:0] k, input logic [7:0] v);
    @(negedge clk);
    m_valid = 1'b1; m_src = s; m_kind = k; m_pay = v;
    @(negedge clk);
    m_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int w, nb, ex;
    logic [7:0] v;
    for (int i = 0; i < NP; i++) done_v[i] = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int t = 0; t < 24; t++) begin
      do_reset();
      for (int i = 0; i < NP; i++) begin
        chk(role_v[i] == 2'd0, "R1 reset role", 32'(role_v[i]), 0);
        chk(!fetch_v[i] && !halt_v[i] && !down_v[i], "R1 reset outputs",
            {29'd0, fetch_v[i], halt_v[i], down_v[i]}, 0);
      end

      w = int'($urandom % NP);
      send(4'(w), 3'd0, 8'($urandom));
      for (int i = 0; i < NP; i++)
        chk(role_v[i] == ((i == w) ? 2'd1 : 2'd2), "R1 first arbitration",
            32'(role_v[i]), (i == w) ? 1 : 2);
      for (int j = 1; j < NP; j++) send(4'((w + j) % NP), 3'd0, 8'h00);
      repeat (2) send(4'($urandom % NP), 3'd0, 8'($urandom));
      nb = 0;
      for (int i = 0; i < NP; i++) begin
        if (role_v[i] == 2'd1) nb++;
        chk(role_v[i] == ((i == w) ? 2'd1 : 2'd2), "R2 later arbitration ignored",
            32'(role_v[i]), (i == w) ? 1 : 2);
      end
      chk(nb == 1, "R1 exactly one bootstrap", 32'(nb), 1);

      send(4'(w), 3'd1, 8'h00);
      for (int i = 0; i < NP; i++) begin
        ex = (i == w) ? 1 : 0;
        chk(fetch_v[i] == 1'(ex), "R3 final fetch", 32'(fetch_v[i]), 32'(ex));
        if (i == w) chk(addr_v[i] == exp_boot_addr(), "R3 reset address", addr_v[i], exp_boot_addr());
      end
      @(negedge clk);
      for (int i = 0; i < NP; i++) chk(!fetch_v[i], "R5 one-cycle pulse", 32'(fetch_v[i]), 0);

      v = (t == 0) ? 8'h00 : (t == 1) ? 8'hFF : 8'($urandom);
      send(4'(w), 3'd2, v);
      for (int i = 0; i < NP; i++) begin
        if (i == w) chk(!fetch_v[i], "R4 bootstrap ignores startup", 32'(fetch_v[i]), 0);
        else begin
          chk(fetch_v[i] && addr_v[i] == exp_app_addr(v), "R4 startup address", addr_v[i], exp_app_addr(v));
          chk(ie_v[i], "R6 interrupts enabled at startup", 32'(ie_v[i]), 1);
        end
      end
      @(negedge clk);
      for (int i = 0; i < NP; i++) chk(!fetch_v[i], "R5 startup pulse ends", 32'(fetch_v[i]), 0);

      for (int i = 0; i < NP; i++) done_v[i] = (i != w);
      @(negedge clk);
      for (int i = 0; i < NP; i++) done_v[i] = 1'b0;
      for (int i = 0; i < NP; i++)
        if (i != w) chk(halt_v[i] && !ie_v[i], "R6 halt on done",
                        {30'd0, halt_v[i], ie_v[i]}, 32'd2);

      send(4'($urandom % NP), 3'd2, 8'($urandom));
      for (int i = 0; i < NP; i++)
        if (i != w) chk(!fetch_v[i] && halt_v[i], "R7 startup ignored when halted",
                        {30'd0, fetch_v[i], halt_v[i]}, 32'd1);
      send(4'(w), 3'd6, 8'($urandom % 2));
      for (int i = 0; i < NP; i++) begin
        ex = (i == w) ? 1 : 0;
        chk(down_v[i] == 1'(ex), "R10 R7 error shuts down only non-halted", 32'(down_v[i]), 32'(ex));
      end

      send(4'(w), 3'd4, 8'h00);
      for (int i = 0; i < NP; i++) begin
        ex = (i == w) ? 0 : 1;
        chk(nmi_v[i] == 1'(ex) && !smi_v[i], "R8 nmi when halted", 32'(nmi_v[i]), 32'(ex));
      end
      send(4'(w), 3'd5, 8'h00);
      for (int i = 0; i < NP; i++) begin
        ex = (i == w) ? 0 : 1;
        chk(smi_v[i] == 1'(ex) && !nmi_v[i], "R8 smi when halted", 32'(smi_v[i]), 32'(ex));
        if (i != w) chk(halt_v[i], "R8 stays halted", 32'(halt_v[i]), 1);
      end

      send(4'(w), 3'd3, 8'h00);
      for (int i = 0; i < NP; i++) begin
        if (i != w) chk(!halt_v[i] && role_v[i] == 2'd2, "R9 init wakes, role kept",
                        {29'd0, halt_v[i], role_v[i]}, 32'd2);
        else chk(down_v[i], "R10 init ignored in shutdown", 32'(down_v[i]), 1);
      end
      v = 8'($urandom);
      send(4'(w), 3'd2, v);
      for (int i = 0; i < NP; i++)
        if (i != w) chk(fetch_v[i] && addr_v[i] == exp_app_addr(v), "R9 restart fetch", addr_v[i], exp_app_addr(v));
    end

    do_reset();
    send(4'd1, 3'd6, 8'h01);
    for (int i = 0; i < NP; i++) chk(down_v[i], "R10 error before arbitration", 32'(down_v[i]), 1);
    send(4'd1, 3'd3, 8'h00);
    send(4'd2, 3'd0, 8'h00);
    send(4'd2, 3'd2, 8'h12);
    for (int i = 0; i < NP; i++)
      chk(down_v[i] && role_v[i] == 2'd0 && !fetch_v[i], "R10 shutdown sticky",
          {29'd0, down_v[i], role_v[i]}, 32'd4);
    do_reset();
    for (int i = 0; i < NP; i++) chk(!down_v[i], "R10 reset clears shutdown", 32'(down_v[i]), 0);
    send(4'd3, 3'd4, 8'h00);
    for (int i = 0; i < NP; i++) chk(!nmi_v[i], "R8 nmi ignored before halt", 32'(nmi_v[i]), 0);

    finish_run();
  end

endmodule